// File: doc/BRIEF.md
# Frame Word-to-Byte Unpacker

This block sits between a user application that supplies Ethernet frames as 64-bit words and a MAC line side that consumes one byte per cycle. Each word enters through a ready/valid handshake together with an end-of-frame flag and a count of the bytes valid in the final word. The block holds one word and emits its bytes one at a time, starting with the least significant lane. It marks the first byte of each frame and the last valid byte of each frame. Either side may stall at any time, and no byte is lost or repeated.

While the frame header streams out, the block checks the two bytes that follow the destination and source addresses, which are frame bytes 12 and 13. If they carry the 802.1Q tag protocol identifier, it raises a VLAN indication. The indication appears together with byte 13 and stays up through the last byte of that frame.

Top module: `frame_unpacker`

## Requirements
- R1: Frame byte 0 of an accepted word is taken from bits 7:0 and sent first. The following bytes come from successively higher 8-bit lanes, and bits 63:56 are sent last.
- R2: A word is accepted only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high exactly when no word is held, or when the last byte of the held word is being taken in that same cycle.
- R3: When `in_last` is set, `in_count` gives the number of valid bytes in that word: 1 to 7 mean that many, and 0 means all 8. When `in_last` is clear, `in_count` is ignored and all 8 bytes are sent.
- R4: `out_sof` is high together with frame byte 0, and only with that byte.
- R5: `out_eof` is high together with the last valid byte of the final word, and only with that byte. A 1-byte frame has both markers on the same byte.
- R6: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_sof` and `out_eof` hold their values.
- R7: When frame bytes 12 and 13 are 0x81 and 0x00, `vlan_flag` rises with byte 13 on the output. It stays high through the frame's end-of-frame byte and is low for the following frame unless that frame matches too. Any other pair of values, or a frame shorter than 14 bytes, leaves the flag low.
- R8: A synchronous active-high `rst` empties the word register and clears the frame byte position and the VLAN indication. In the cycle after reset, `out_valid` and `vlan_flag` are low and `in_ready` is high.
- R9: With `out_ready` held high and words offered back to back, the output presents a byte in every cycle after the first word is accepted. There are no idle cycles between words or between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered by the application |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 64 | Frame bytes, lowest-numbered byte in bits 7:0 |
| in_last | input | 1 | Word is the final word of the frame |
| in_count | input | 3 | Valid bytes in the final word, 0 means 8 |
| out_valid | output | 1 | A byte is presented |
| out_ready | input | 1 | Line side takes the presented byte |
| out_byte | output | 8 | Frame byte |
| out_sof | output | 1 | Presented byte is frame byte 0 |
| out_eof | output | 1 | Presented byte is the frame's last byte |
| vlan_flag | output | 1 | An 802.1Q tag follows the source address |

## Verification
A new word can be loaded in the same cycle that the last byte of the held word is taken. This is the case where a byte could be lost or sent twice. The bench provokes it with back-to-back words under a line side that is always ready, one that toggles, and one that stalls pseudo-randomly, while frame lengths sweep from 1 to 40 bytes. The bench keeps its own count of the bytes left in the held word. Every cycle it compares `in_ready` and `out_valid` against that count, and it checks each byte taken against the byte sequence it generated.

// File: rtl/frame_unpacker.sv
module frame_unpacker #(
  parameter int DATA_W = 64,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [$clog2(DATA_W/8)-1:0] in_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_sof,
  output logic              out_eof,
  output logic              vlan_flag
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] TAG_HI  = POS_W'(12);
  localparam logic [POS_W-1:0] TAG_LO  = POS_W'(13);

  logic [DATA_W-1:0] word_q;
  logic              full_q, last_q, hi_q, tag_q;
  logic [LANE_W-1:0] lane_q, end_q;
  logic [POS_W-1:0]  pos_q;
  logic              at_end, take, drain, load, tag_now;

  assign at_end    = lane_q == end_q;
  assign take      = full_q & out_ready;
  assign drain     = take & at_end;
  assign in_ready  = !full_q || drain;
  assign load      = in_valid & in_ready;

  assign out_valid = full_q;
  assign out_byte  = word_q[{lane_q, 3'b000} +: 8];
  assign out_sof   = full_q && (pos_q == '0);
  assign out_eof   = full_q & last_q & at_end;
  assign tag_now   = full_q && (pos_q == TAG_LO) && hi_q && (out_byte == 8'h00);
  assign vlan_flag = tag_q | tag_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
      lane_q <= '0;
      end_q  <= '0;
      pos_q  <= '0;
      hi_q   <= 1'b0;
      tag_q  <= 1'b0;
    end else begin
      if (load) begin
        word_q <= in_data;
        last_q <= in_last;
        end_q  <= in_last ? in_count - LANE_W'(1) : '1;
        lane_q <= '0;
        full_q <= 1'b1;
      end else if (drain) begin
        full_q <= 1'b0;
      end else if (take) begin
        lane_q <= lane_q + LANE_W'(1);
      end
      if (take) begin
        if (out_eof) begin
          pos_q <= '0;
          hi_q  <= 1'b0;
          tag_q <= 1'b0;
        end else begin
          if (pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
          if (pos_q == TAG_HI) hi_q <= (out_byte == 8'h81);
          if (tag_now) tag_q <= 1'b1;
        end
      end
    end
  end

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_sof_follows_eof_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_eof |=> !out_valid || out_sof);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_sof) && $stable(out_eof));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
    vlan_flag && !(out_valid && out_ready && out_eof) |=> vlan_flag);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_eof |=> !vlan_flag);

  p_reset_empty_r8: assert property (@(posedge clk)
    rst |=> !out_valid && !vlan_flag && in_ready);
endmodule

// File: tb/frame_unpacker_bench.sv
module frame_unpacker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 4096;
  localparam int MAXW = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0, out_valid, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0] in_count = '0;
  logic [7:0] out_byte;
  logic out_sof, out_eof, vlan_flag;

  frame_unpacker u_frame_unpacker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_count(in_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_sof(out_sof), .out_eof(out_eof), .vlan_flag(vlan_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] eb [MAXB];
  bit esof [MAXB], eeof [MAXB], evlan [MAXB];
  int epat [MAXB];
  logic [63:0] wd [MAXW];
  bit wl [MAXW];
  logic [2:0] wc [MAXW];
  int wn [MAXW], wpat [MAXW];
  int nb = 0, nw = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build();
    logic [7:0] fb [40];
    for (int p = 0; p < 3; p++)
      for (int len = 1; len <= 40; len++) begin
        bit tag;
        for (int i = 0; i < len; i++) fb[i] = 8'((len*7 + i*13 + p*5) & 255);
        if (len >= 14 && len % 3 == 0) begin fb[12] = 8'h81; fb[13] = 8'h00; end
        if (len >= 14 && len % 3 == 1) begin fb[12] = 8'h81; fb[13] = 8'h01; end
        if (len >= 14 && len % 3 == 2) begin fb[12] = 8'h88; fb[13] = 8'h00; end
        tag = len >= 14 && fb[12] == 8'h81 && fb[13] == 8'h00;
        for (int i = 0; i < len; i++) begin
          eb[nb] = fb[i]; esof[nb] = (i == 0); eeof[nb] = (i == len-1);
          evlan[nb] = tag && i >= 13; epat[nb] = p; nb++;
        end
        for (int w = 0; w*8 < len; w++) begin
          logic [63:0] d = '0;
          int n = (len - w*8 >= 8) ? 8 : len - w*8;
          for (int k = 0; k < n; k++) d[k*8 +: 8] = fb[w*8+k];
          wd[nw] = d; wl[nw] = (w*8 + 8 >= len); wn[nw] = n; wpat[nw] = p;
          wc[nw] = wl[nw] ? 3'(len % 8) : 3'd3;
          nw++;
        end
      end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int bi = 0, wi = 0, rem = 0, cyc = 0;
    bit pstall = 0, psof = 0, peof = 0;
    logic [7:0] pbyte = '0;
    build();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk(!out_valid && in_ready && !vlan_flag, "R8 reset state", {out_valid, in_ready, vlan_flag}, 3'b010);

    while (bi < nb) begin
      bit acc, xf;
      int pp;
      @(negedge clk);
      cyc++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pp = epat[bi];
      out_ready = (pp == 0) ? 1'b1 : (pp == 1) ? 1'(cyc & 1) : lf[3];
      if (wi < nw) begin
        in_valid = (wpat[wi] == 2) ? lf[7] : 1'b1;
        in_data = wd[wi]; in_last = wl[wi]; in_count = wc[wi];
      end else in_valid = 1'b0;
      #1;
      chk(out_valid == (rem > 0), "R9 R3 out_valid vs bytes held", out_valid, rem > 0);
      chk(in_ready == (rem == 0 || (rem == 1 && out_ready)), "R2 in_ready", in_ready, rem == 0 || (rem == 1 && out_ready));
      if (pstall)
        chk(out_byte == pbyte && out_sof == psof && out_eof == peof, "R6 stall hold", out_byte, pbyte);
      if (out_valid) begin
        chk(out_byte == eb[bi], "R1 R3 byte order", out_byte, eb[bi]);
        chk(out_sof == esof[bi], "R4 sof", out_sof, esof[bi]);
        chk(out_eof == eeof[bi], "R5 eof", out_eof, eeof[bi]);
        chk(vlan_flag == evlan[bi], "R7 vlan flag", vlan_flag, evlan[bi]);
      end
      pstall = out_valid && !out_ready;
      pbyte = out_byte; psof = out_sof; peof = out_eof;
      xf = out_valid && out_ready;
      acc = in_valid && in_ready;
      @(posedge clk);
      if (xf) begin bi++; rem--; end
      if (acc) begin rem = wn[wi]; wi++; end
    end

    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    begin
      logic [63:0] d0, d1;
      d0 = 64'h0706050403020100;
      d1 = 64'h0F0E_0081_0B0A0908;
      in_valid = 1'b1; in_data = d0; in_last = 1'b0; in_count = 3'd0;
      @(posedge clk); @(negedge clk);
      in_data = d1;
      #1;
      while (!in_ready) begin @(posedge clk); @(negedge clk); #1; end
      @(posedge clk); @(negedge clk); in_valid = 1'b0;
      for (int k = 0; k < 12 && !vlan_flag; k++) begin @(posedge clk); @(negedge clk); #1; end
      chk(vlan_flag == 1'b1 && out_byte == 8'h00, "R7 flag with byte 13", vlan_flag, 1);
      rst = 1'b1;
      @(posedge clk); @(negedge clk); rst = 1'b0; #1;
      chk(!out_valid && in_ready && !vlan_flag, "R8 mid-frame reset", {out_valid, in_ready, vlan_flag}, 3'b010);
      in_valid = 1'b1; in_data = 64'h5A; in_last = 1'b1; in_count = 3'd1;
      @(posedge clk); @(negedge clk); in_valid = 1'b0; #1;
      chk(out_valid && out_byte == 8'h5A, "R3 one-byte frame", out_byte, 8'h5A);
      chk(out_sof && out_eof, "R4 R5 single byte markers", {out_sof, out_eof}, 2'b11);
      @(posedge clk); @(negedge clk); #1;
      chk(!out_valid, "R5 frame ended", out_valid, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule